// File: doc/BRIEF.md
# Supply Supervisor with Watchdog

This block is a clocked supervisor for a processor subsystem. It takes supply-status flags that have already been digitized (supply above the reset threshold, supply above the battery level), a watchdog strobe and a watchdog enable. From these it produces an active-low processor reset, an active-low watchdog-expired flag, an active-low low-line flag and a battery-on flag. It also forces the processor's active-low memory chip-enable inactive whenever the supply is too low. This stops corrupt writes during brownouts, power-up and power-down.

Every status input first passes through a two-flop synchronizer. The reset is held for a parameterized number of ticks after the supply recovers. The watchdog counts ticks between strobe edges; either edge polarity counts as service. If the strobe stays quiet for a full period, the watchdog issues a fixed-width reset pulse. It then starts a fresh period at the end of that pulse, and keeps pulsing until the strobe moves again. The block has no streaming data path: every pin is a plain level signal and none of them has back-pressure.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst_n` is low the outputs read `rst_n_o`=0, `lowline_n_o`=0, `ce_n_o`=1, `batt_on_o`=0, `wdo_n_o`=1.
- R2: `rst_n_o` is 0 while the synchronized supply flag is 0 (two ticks after `supply_ok_i` falls). After `supply_ok_i` rises, `rst_n_o` stays 0 for HOLD_TICKS further ticks and reads 1 from tick HOLD_TICKS+2 onward.
- R3: `lowline_n_o` equals the supply flag delayed by the two synchronizer stages.
- R4: `ce_n_o` equals `ce_n_i` (combinationally) while the synchronized supply flag is 1. It is 1 while that flag is 0, whatever the value of `ce_n_i`.
- R5: `batt_on_o` is 1 only when both synchronized flags, supply-ok and over-battery, are 1.
- R6: With the watchdog enabled and no strobe edge, `rst_n_o` falls PERIOD_TICKS+3 ticks after the last strobe edge at the input.
- R7: A watchdog reset pulse lasts exactly HOLD_TICKS ticks.
- R8: While the strobe stays quiet, another pulse starts PERIOD_TICKS ticks after each pulse ends.
- R9: `wdo_n_o` goes to 0 on the tick the first timeout pulse starts. It stays 0 across repeated pulses and returns to 1 three ticks after the next strobe edge.
- R10: Strobe edges of either polarity spaced at most PERIOD_TICKS ticks apart never cause a watchdog reset.
- R11: With `wd_enable_i`=0 no timeout occurs, and `wdo_n_o` returns to 1 three ticks after the enable drops.
- R12: A low-supply reset clears the watchdog count. The next timeout falls PERIOD_TICKS ticks after the supply hold ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flops |
| supply_ok_i | input | 1 | Supply above reset threshold |
| over_batt_i | input | 1 | Supply above battery level |
| wd_strobe_i | input | 1 | Watchdog service strobe; any edge services |
| wd_enable_i | input | 1 | Watchdog enable (0 = strobe unconnected) |
| ce_n_i | input | 1 | Processor memory chip-enable, active low |
| rst_n_o | output | 1 | Processor reset, active low |
| wdo_n_o | output | 1 | Watchdog expired, active low |
| lowline_n_o | output | 1 | Low supply flag, active low |
| batt_on_o | output | 1 | High when mains supply feeds the output |
| ce_n_o | output | 1 | Gated memory chip-enable, active low |

## Verification
A change at any status input reaches `lowline_n_o`, `batt_on_o` and the `ce_n_o` gating after two ticks, which are the synchronizer stages. A strobe edge takes effect in the watchdog on the third tick. A supply rise releases reset on tick HOLD_TICKS+2. `ce_n_o` follows `ce_n_i` within the same cycle. The bench drives every input 2 ns after a rising edge and advances a whole number of ticks. It then compares each output against a cycle index computed from these latencies. In the watchdog sweeps it samples on every tick of the window, so each edge of a pulse is pinned to a single cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int unsigned STATUS_W = 4;

  typedef struct packed {
    logic supply_ok;
    logic over_batt;
    logic strobe;
    logic wd_enable;
  } status_t;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[LAST];
  end
endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int unsigned HOLD_TICKS = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_i,
  output logic hold_o
);
  localparam int unsigned CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (low_i) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign hold_o = busy;

  // R2: a low supply always re-arms the hold
  p_low_rearms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    low_i |=> hold_o);
  // R2: the hold only releases while the supply is good
  p_release_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> !low_i);
  // R2: count stays inside its window
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned PERIOD_TICKS = 200_000_000,
  parameter int unsigned PULSE_TICKS  = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic enable_i,
  input  logic strobe_i,
  output logic pulse_o,
  output logic expired_o
);
  localparam int unsigned PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam int unsigned UW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [PW-1:0] PER_LAST = PW'(PERIOD_TICKS - 1);
  localparam logic [UW-1:0] PUL_LAST = UW'(PULSE_TICKS - 1);

  logic          strobe_q;
  logic          edge_seen;
  logic          quiet;
  logic [PW-1:0] wd_cnt;
  logic [UW-1:0] pul_cnt;
  logic          pulse_q;
  logic          expired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_i;
  end

  assign edge_seen = strobe_i ^ strobe_q;
  assign quiet     = clear_i | ~enable_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt    <= '0;
      pul_cnt   <= '0;
      pulse_q   <= 1'b0;
      expired_q <= 1'b0;
    end else if (quiet) begin
      wd_cnt    <= '0;
      pul_cnt   <= '0;
      pulse_q   <= 1'b0;
      expired_q <= 1'b0;
    end else begin
      if (pulse_q) begin
        if (pul_cnt == PUL_LAST) begin
          pulse_q <= 1'b0;
          pul_cnt <= '0;
        end else begin
          pul_cnt <= pul_cnt + 1'b1;
        end
        wd_cnt <= '0;
      end else if (edge_seen) begin
        wd_cnt <= '0;
      end else if (wd_cnt == PER_LAST) begin
        wd_cnt    <= '0;
        pul_cnt   <= '0;
        pulse_q   <= 1'b1;
        expired_q <= 1'b1;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
      if (edge_seen) expired_q <= 1'b0;
    end
  end

  assign pulse_o   = pulse_q;
  assign expired_o = expired_q;

  // R11: disabled or cleared watchdog stays silent
  p_quiet_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> !pulse_o && !expired_o);
  // R9: a serviced strobe releases the expired flag
  p_service_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen && !quiet |=> !expired_o);
  // R9: a new pulse always comes with the expired flag
  p_pulse_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> expired_o);
  // R8: the period count is held during a pulse
  p_idle_in_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> wd_cnt == '0);
  // R7: pulse counter stays in range
  p_pulse_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pul_cnt <= PUL_LAST);
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int unsigned HOLD_TICKS   = 25_000_000,
  parameter int unsigned PERIOD_TICKS = 200_000_000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic over_batt_i,
  input  logic wd_strobe_i,
  input  logic wd_enable_i,
  input  logic ce_n_i,
  output logic rst_n_o,
  output logic wdo_n_o,
  output logic lowline_n_o,
  output logic batt_on_o,
  output logic ce_n_o
);
  import sup_pkg::*;

  status_t raw;
  status_t syn;
  logic    low_supply;
  logic    hold;
  logic    wd_pulse;
  logic    wd_expired;

  assign raw = '{supply_ok: supply_ok_i, over_batt: over_batt_i,
                 strobe: wd_strobe_i, wd_enable: wd_enable_i};

  sup_sync #(.WIDTH(STATUS_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d_i (raw),
    .q_o (syn)
  );

  assign low_supply = ~syn.supply_ok;

  sup_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) i_hold (
    .clk (clk),
    .rst_n (rst_n),
    .low_i (low_supply),
    .hold_o (hold)
  );

  sup_watchdog #(.PERIOD_TICKS(PERIOD_TICKS), .PULSE_TICKS(HOLD_TICKS)) i_wdog (
    .clk (clk),
    .rst_n (rst_n),
    .clear_i (hold),
    .enable_i (syn.wd_enable),
    .strobe_i (syn.strobe),
    .pulse_o (wd_pulse),
    .expired_o (wd_expired)
  );

  assign rst_n_o     = ~(low_supply | hold | wd_pulse);
  assign wdo_n_o     = ~wd_expired;
  assign lowline_n_o = syn.supply_ok;
  assign batt_on_o   = syn.supply_ok & syn.over_batt;
  assign ce_n_o      = syn.supply_ok ? ce_n_i : 1'b1;

  // R4: memory enable is blocked whenever low-line is flagged
  p_ce_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lowline_n_o |-> ce_n_o);
  // R5: battery-on implies a good supply
  p_batt_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
    batt_on_o |-> lowline_n_o);
  // R2: low-line always means reset
  p_lowline_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lowline_n_o |-> !rst_n_o);
  // R12: supply hold and watchdog pulse never overlap
  p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !wd_pulse);
endmodule

// File: tb/test_supply_supervisor.sv
module test_supply_supervisor;
  localparam int HOLD = 5;
  localparam int PER  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok_i = 1'b0, over_batt_i = 1'b0, wd_strobe_i = 1'b0;
  logic wd_enable_i = 1'b0, ce_n_i = 1'b0;
  logic rst_n_o, wdo_n_o, lowline_n_o, batt_on_o, ce_n_o;
  int   n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  supply_supervisor #(.HOLD_TICKS(HOLD), .PERIOD_TICKS(PER), .SYNC_STAGES(2)) i_supply_supervisor (
    .clk, .rst_n, .supply_ok_i, .over_batt_i, .wd_strobe_i, .wd_enable_i,
    .ce_n_i, .rst_n_o, .wdo_n_o, .lowline_n_o, .batt_on_o, .ce_n_o
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic arm();
    wd_enable_i = 1'b0;
    tick(4);
    wd_enable_i = 1'b1;
    wd_strobe_i = ~wd_strobe_i;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 rst_n_o", rst_n_o, 1'b0);
    chk("R1 lowline_n_o", lowline_n_o, 1'b0);
    chk("R1 ce_n_o", ce_n_o, 1'b1);
    chk("R1 batt_on_o", batt_on_o, 1'b0);
    chk("R1 wdo_n_o", wdo_n_o, 1'b1);
    rst_n = 1'b1;
    tick(2);

    // R2 / R3: supply rise
    supply_ok_i = 1'b1;
    for (int k = 1; k <= HOLD + 4; k++) begin
      tick(1);
      chk("R2 rise", rst_n_o, k >= HOLD + 2);
      chk("R3 rise", lowline_n_o, k >= 2);
    end

    // R4 / R5 with good supply
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 2; b++) begin
        ce_n_i = c[0];
        over_batt_i = b[0];
        tick(3);
        chk("R4 follow", ce_n_o, c[0]);
        chk("R5 good", batt_on_o, b[0]);
      end
    end

    // R2 / R3: supply fall
    supply_ok_i = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      tick(1);
      chk("R2 fall", rst_n_o, k < 2);
      chk("R3 fall", lowline_n_o, k < 2);
    end
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 2; b++) begin
        ce_n_i = c[0];
        over_batt_i = b[0];
        #1;
        chk("R4 blocked", ce_n_o, 1'b1);
        chk("R5 low", batt_on_o, 1'b0);
        tick(1);
      end
    end
    wd_enable_i = 1'b1;
    for (int k = 1; k <= 3 * PER; k++) begin
      tick(1);
      chk("R2 held", rst_n_o, 1'b0);
    end
    wd_enable_i = 1'b0;
    over_batt_i = 1'b1;
    supply_ok_i = 1'b1;
    tick(HOLD + 4);

    // R6 / R7 / R8 / R9: quiet strobe
    arm();
    for (int k = 1; k <= 3 + 2 * PER + 2 * HOLD + 2; k++) begin
      logic ex_rst, ex_wdo;
      int   a1, a2;
      a1 = 3 + PER;
      a2 = a1 + HOLD + PER;
      tick(1);
      ex_rst = !((k >= a1 && k < a1 + HOLD) || (k >= a2 && k < a2 + HOLD));
      ex_wdo = !(k >= a1);
      if (k <= a1)            chk("R6 timeout", rst_n_o, ex_rst);
      else if (k <= a1 + HOLD) chk("R7 width", rst_n_o, ex_rst);
      else                     chk("R8 repeat", rst_n_o, ex_rst);
      chk("R9 wdo low", wdo_n_o, ex_wdo);
    end
    wd_strobe_i = ~wd_strobe_i;
    for (int k = 1; k <= 4; k++) begin
      tick(1);
      chk("R9 release", wdo_n_o, k >= 3);
    end

    // R10: service gaps up to the period, both edge polarities
    for (int g = 1; g <= PER; g++) begin
      arm();
      for (int r = 0; r < 3; r++) begin
        for (int k = 1; k <= g; k++) begin
          tick(1);
          chk("R10 serviced", rst_n_o, 1'b1);
        end
        wd_strobe_i = ~wd_strobe_i;
      end
      tick(3);
      chk("R10 wdo", wdo_n_o, 1'b1);
    end

    // R11: disabled
    wd_enable_i = 1'b0;
    tick(4);
    for (int k = 1; k <= 3 * PER; k++) begin
      tick(1);
      chk("R11 rst", rst_n_o, 1'b1);
      chk("R11 wdo", wdo_n_o, 1'b1);
    end
    arm();
    tick(PER + 3);
    chk("R11 pre", wdo_n_o, 1'b0);
    wd_enable_i = 1'b0;
    tick(2);
    chk("R11 lag", wdo_n_o, 1'b0);
    tick(1);
    chk("R11 drop", wdo_n_o, 1'b1);
    tick(HOLD + 2);

    // R12: supply dip clears the watchdog count
    arm();
    tick(PER - 2);
    supply_ok_i = 1'b0;
    tick(4);
    supply_ok_i = 1'b1;
    tick(HOLD + 2 + PER - 1);
    chk("R12 before", rst_n_o, 1'b1);
    tick(1);
    chk("R12 timeout", rst_n_o, 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule